// File: doc/BRIEF.md
# Store-Address Recovery Controller

This block sits beside a pair of cooperating hardware threads that run the same program. The leading thread runs a reduced copy of the program and the trailing thread runs the full copy. The block keeps a small set of unique memory addresses whose contents may differ between the two thread contexts. An address enters the set when the leading thread retires a store that the trailing thread has not yet matched. It also enters when the trailing thread retires a store that the leading thread left out. A leading-thread store leaves the set once the trailing thread retires its companion store.

When a removal misprediction is reported, the block runs a fixed repair sequence. It first waits through a short startup delay. It then requests the whole register file in fixed-width beats, and then every tracked address in beats of the same kind, each address marked with the kind of repair it needs. At the end it empties the set and raises a single-cycle completion pulse. Register files, caches and data movement belong to the surrounding logic; only the request side is modelled here.

Top module: `store_recovery_ctrl`

## Requirements
- R1: Stores to an address that is already tracked never create a second entry; during repair each tracked address is requested exactly once.
- R2: A leading-thread store to an untracked address creates an entry. During repair its lane shows `mem_copy_pend`=1, meaning trailing-thread state at that location must be undone.
- R3: A trailing-thread store with `trail_st_lead_skipped`=1 tracks its address with `mem_copy_skip`=1, meaning the location must be written into leading-thread state.
- R4: Each entry counts outstanding leading-thread stores. Each non-skipped trailing-thread store to that address takes one away, and the entry is freed when the count reaches zero and no skip mark is set. A non-skipped trailing-thread store to an untracked address has no effect.
- R5: After `mispredict` is sampled while idle, no copy request appears for START_DELAY (default 5) cycles. The first register beat appears in cycle START_DELAY+1 after the sampling edge.
- R6: The register restore takes ceil(NUM_REGS/REG_LANES) consecutive beats (default 16). In beat b, lane g requests register b*REG_LANES+g.
- R7: Memory beats follow the register beats directly. There are ceil(n/MEM_LANES) of them for n tracked addresses, at most MEM_LANES (default 4) addresses per beat. There are none when n is 0.
- R8: `done` is high for exactly one cycle, in the cycle after the last copy beat. The set is empty afterwards and `busy` is low in the next cycle.
- R9: An insert that finds all DEPTH entries in use, or a leading-thread store that finds its count at the maximum, is dropped and sets `overflow`. The flag stays set until `done`.
- R10: Store events that arrive while `busy` is high do not change the tracked set.
- R11: `mispredict` while `busy` is high neither restarts nor extends the sequence.
- R12: When a leading-thread store and a trailing-thread store arrive in the same cycle, the leading one is applied first. A matched pair to an untracked address therefore leaves nothing tracked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lead_st_vld | input | 1 | Leading thread retired a store |
| lead_st_addr | input | ADDR_W | Address of that store |
| trail_st_vld | input | 1 | Trailing thread retired a store |
| trail_st_addr | input | ADDR_W | Address of that store |
| trail_st_lead_skipped | input | 1 | The leading thread did not perform this store |
| mispredict | input | 1 | Removal misprediction detected; starts repair |
| reg_copy_vld | output | 1 | Register copy beat |
| reg_copy_idx | output | REG_LANES*RIDX_W | Register index per lane, lane 0 lowest |
| reg_copy_mask | output | REG_LANES | Lane carries a real register |
| mem_copy_vld | output | 1 | Memory copy beat |
| mem_copy_addr | output | MEM_LANES*ADDR_W | Address per lane, lane 0 lowest |
| mem_copy_mask | output | MEM_LANES | Lane carries an address |
| mem_copy_pend | output | MEM_LANES | Lane needs trailing-state undo |
| mem_copy_skip | output | MEM_LANES | Lane needs leading-state write |
| busy | output | 1 | Repair sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| overflow | output | 1 | An insert was dropped since the last completion |

## Verification
The bench targets the following corner cases.
- Repeated stores to one address: a design that allocated on every store would request that address more than once.
- Counts that reach zero only after several pairings: a design without a per-entry count would free the entry early and lose the repair.
- A pair arriving in the same cycle: the wrong ordering would leave a stale entry behind.
- The set filling up: the 33rd distinct address, or a saturated count, must be dropped and flagged without disturbing the entries already held.
- Stores and a second `mispredict` during repair: the bench checks that these neither enter the set nor shift the timing of `done`. The timing is the startup delay, then the register beats, then ceil(n/4) memory beats.

// File: rtl/srec_pkg.sv
package srec_pkg;
   typedef enum logic [2:0] {
      S_IDLE,
      S_START,
      S_REGS,
      S_MEM,
      S_FIN
   } srec_state_e;
endpackage

// File: rtl/srec_addr_set.sv
module srec_addr_set #(
   parameter int ADDR_W = 16,
   parameter int DEPTH  = 32,
   parameter int CNT_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic              lead_vld,
   input  logic [ADDR_W-1:0] lead_addr,
   input  logic              trail_vld,
   input  logic [ADDR_W-1:0] trail_addr,
   input  logic              trail_skip,
   input  logic [DEPTH-1:0]  drain,
   input  logic              flush,
   output logic [DEPTH-1:0]  ent_valid,
   output logic [ADDR_W-1:0] ent_addr [DEPTH],
   output logic [DEPTH-1:0]  ent_pend,
   output logic [DEPTH-1:0]  ent_skip,
   output logic              overflow
);
   localparam int IDX_W = $clog2(DEPTH);
   localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

   logic [DEPTH-1:0]  v_q, k_q, v1, k1, v2, k2;
   logic [ADDR_W-1:0] a_q [DEPTH];
   logic [ADDR_W-1:0] a1  [DEPTH];
   logic [ADDR_W-1:0] a2  [DEPTH];
   logic [CNT_W-1:0]  c_q [DEPTH];
   logic [CNT_W-1:0]  c1  [DEPTH];
   logic [CNT_W-1:0]  c2  [DEPTH];
   logic [DEPTH-1:0]  l_hit, t_hit;
   logic [IDX_W-1:0]  l_slot, t_slot;
   logic              l_free, t_free, l_go, t_go, l_need, t_need, l_sat, ovf_q, ovf_d;

   always_comb begin
      // stage 1: leading-thread store
      l_go   = accept & lead_vld;
      l_hit  = '0;
      l_sat  = 1'b0;
      l_slot = '0;
      l_free = 1'b0;
      for (int i = 0; i < DEPTH; i++) begin
         l_hit[i] = v_q[i] && (a_q[i] == lead_addr);
         if (l_hit[i] && c_q[i] == CMAX) l_sat = 1'b1;
      end
      for (int i = DEPTH-1; i >= 0; i--) begin
         if (!v_q[i]) begin
            l_slot = IDX_W'(i);
            l_free = 1'b1;
         end
      end
      l_need = l_go && !(|l_hit);
      for (int i = 0; i < DEPTH; i++) begin
         v1[i] = v_q[i];
         a1[i] = a_q[i];
         c1[i] = c_q[i];
         k1[i] = k_q[i];
         if (l_go && l_hit[i] && c_q[i] != CMAX) begin
            c1[i] = c_q[i] + 1'b1;
         end else if (l_need && l_free && l_slot == IDX_W'(i)) begin
            v1[i] = 1'b1;
            a1[i] = lead_addr;
            c1[i] = CNT_W'(1);
            k1[i] = 1'b0;
         end
      end
      // stage 2: trailing-thread store, seen after stage 1
      t_hit  = '0;
      t_slot = '0;
      t_free = 1'b0;
      for (int i = 0; i < DEPTH; i++) t_hit[i] = v1[i] && (a1[i] == trail_addr);
      for (int i = DEPTH-1; i >= 0; i--) begin
         if (!v1[i]) begin
            t_slot = IDX_W'(i);
            t_free = 1'b1;
         end
      end
      t_need = accept && trail_vld && trail_skip && !(|t_hit);
      for (int i = 0; i < DEPTH; i++) begin
         v2[i] = v1[i];
         a2[i] = a1[i];
         c2[i] = c1[i];
         k2[i] = k1[i];
         if (accept && trail_vld && t_hit[i]) begin
            if (trail_skip) k2[i] = 1'b1;
            else if (c1[i] != '0) c2[i] = c1[i] - 1'b1;
            v2[i] = (c2[i] != '0) || k2[i];
         end else if (t_need && t_free && t_slot == IDX_W'(i)) begin
            v2[i] = 1'b1;
            a2[i] = trail_addr;
            c2[i] = '0;
            k2[i] = 1'b1;
         end
      end
      v2 = v2 & ~drain;
      ovf_d = ovf_q | (l_need & ~l_free) | (l_go & l_sat) | (t_need & ~t_free);
   end

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         v_q   <= '0;
         k_q   <= '0;
         ovf_q <= 1'b0;
         for (int i = 0; i < DEPTH; i++) begin
            a_q[i] <= '0;
            c_q[i] <= '0;
         end
      end else begin
         v_q   <= v2;
         k_q   <= k2;
         ovf_q <= ovf_d;
         for (int i = 0; i < DEPTH; i++) begin
            a_q[i] <= a2[i];
            c_q[i] <= c2[i];
         end
      end
   end

   always_comb begin
      for (int i = 0; i < DEPTH; i++) begin
         ent_addr[i] = a_q[i];
         ent_pend[i] = v_q[i] && (c_q[i] != '0);
         ent_skip[i] = v_q[i] && k_q[i];
      end
   end
   assign ent_valid = v_q;
   assign overflow  = ovf_q;
endmodule

// File: rtl/srec_pick.sv
module srec_pick #(
   parameter int DEPTH = 32,
   parameter int LANES = 4
) (
   input  logic [DEPTH-1:0]         pool,
   output logic [LANES-1:0]         lane_vld,
   output logic [$clog2(DEPTH)-1:0] lane_idx [LANES],
   output logic [DEPTH-1:0]         taken,
   output logic                     last_group
);
   localparam int IDX_W = $clog2(DEPTH);
   logic [DEPTH-1:0] rem;

   always_comb begin
      rem = pool;
      for (int g = 0; g < LANES; g++) begin
         lane_idx[g] = '0;
         for (int i = DEPTH-1; i >= 0; i--) begin
            if (rem[i]) lane_idx[g] = IDX_W'(i);
         end
         lane_vld[g] = |rem;
         if (|rem) rem[lane_idx[g]] = 1'b0;
      end
      taken      = pool & ~rem;
      last_group = (rem == '0);
   end
endmodule

// File: rtl/srec_seq.sv
module srec_seq
   import srec_pkg::*;
#(
   parameter int START_DELAY = 5,
   parameter int REG_BEATS   = 16,
   parameter int CW          = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          mispredict,
   input  logic          any_left,
   input  logic          last_group,
   output srec_state_e   state,
   output logic [CW-1:0] beat
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= S_IDLE;
         beat  <= '0;
      end else begin
         case (state)
            S_IDLE: if (mispredict) begin
               state <= S_START;
               beat  <= '0;
            end
            S_START: if (beat == CW'(START_DELAY-1)) begin
               state <= S_REGS;
               beat  <= '0;
            end else beat <= beat + 1'b1;
            S_REGS: if (beat == CW'(REG_BEATS-1)) begin
               state <= any_left ? S_MEM : S_FIN;
               beat  <= '0;
            end else beat <= beat + 1'b1;
            S_MEM:   if (last_group) state <= S_FIN;
            default: state <= S_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/store_recovery_ctrl.sv
module store_recovery_ctrl
   import srec_pkg::*;
#(
   parameter int ADDR_W      = 16,
   parameter int DEPTH       = 32,
   parameter int CNT_W       = 4,
   parameter int NUM_REGS    = 64,
   parameter int REG_LANES   = 4,
   parameter int MEM_LANES   = 4,
   parameter int START_DELAY = 5,
   localparam int RIDX_W     = $clog2(NUM_REGS)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        lead_st_vld,
   input  logic [ADDR_W-1:0]           lead_st_addr,
   input  logic                        trail_st_vld,
   input  logic [ADDR_W-1:0]           trail_st_addr,
   input  logic                        trail_st_lead_skipped,
   input  logic                        mispredict,
   output logic                        reg_copy_vld,
   output logic [REG_LANES*RIDX_W-1:0] reg_copy_idx,
   output logic [REG_LANES-1:0]        reg_copy_mask,
   output logic                        mem_copy_vld,
   output logic [MEM_LANES*ADDR_W-1:0] mem_copy_addr,
   output logic [MEM_LANES-1:0]        mem_copy_mask,
   output logic [MEM_LANES-1:0]        mem_copy_pend,
   output logic [MEM_LANES-1:0]        mem_copy_skip,
   output logic                        busy,
   output logic                        done,
   output logic                        overflow
);
   localparam int REG_BEATS = (NUM_REGS + REG_LANES - 1) / REG_LANES;
   localparam int CNT_TOP   = (START_DELAY > REG_BEATS) ? START_DELAY : REG_BEATS;
   localparam int CW        = $clog2(CNT_TOP + 1);
   localparam int IDX_W     = $clog2(DEPTH);

   initial begin
      assert (DEPTH >= 2 && MEM_LANES >= 1 && MEM_LANES <= DEPTH)
         else $error("store_recovery_ctrl: bad DEPTH/MEM_LANES");
      assert (NUM_REGS >= 2 && REG_LANES >= 1 && START_DELAY >= 1 && CNT_W >= 1)
         else $error("store_recovery_ctrl: bad register or delay parameters");
   end

   srec_state_e       st;
   logic [CW-1:0]     beat;
   logic [DEPTH-1:0]  ent_valid, ent_pend, ent_skip, taken, drain;
   logic [ADDR_W-1:0] ent_addr [DEPTH];
   logic [MEM_LANES-1:0] lane_vld;
   logic [IDX_W-1:0]  lane_idx [MEM_LANES];
   logic              last_group, in_mem, accept;

   assign accept = (st == S_IDLE);
   assign in_mem = (st == S_MEM);
   assign drain  = in_mem ? taken : '0;

   srec_addr_set #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_set (
      .clk, .rst_n, .accept,
      .lead_vld(lead_st_vld), .lead_addr(lead_st_addr),
      .trail_vld(trail_st_vld), .trail_addr(trail_st_addr),
      .trail_skip(trail_st_lead_skipped),
      .drain, .flush(st == S_FIN),
      .ent_valid, .ent_addr, .ent_pend, .ent_skip, .overflow
   );

   srec_pick #(.DEPTH(DEPTH), .LANES(MEM_LANES)) u_pick (
      .pool(ent_valid), .lane_vld, .lane_idx, .taken, .last_group
   );

   srec_seq #(.START_DELAY(START_DELAY), .REG_BEATS(REG_BEATS), .CW(CW)) u_seq (
      .clk, .rst_n, .mispredict,
      .any_left(|ent_valid), .last_group,
      .state(st), .beat
   );

   assign busy         = (st != S_IDLE);
   assign done         = (st == S_FIN);
   assign reg_copy_vld = (st == S_REGS);
   assign mem_copy_vld = in_mem;

   for (genvar g = 0; g < REG_LANES; g++) begin : g_reg_lane
      logic [CW+$clog2(REG_LANES+1)+1:0] full_idx;
      assign full_idx = beat * REG_LANES + g;
      assign reg_copy_idx[g*RIDX_W +: RIDX_W] = RIDX_W'(full_idx);
      if (NUM_REGS % REG_LANES == 0) begin : g_even
         assign reg_copy_mask[g] = reg_copy_vld;
      end else begin : g_ragged
         assign reg_copy_mask[g] = reg_copy_vld && (full_idx < NUM_REGS);
      end
   end

   for (genvar g = 0; g < MEM_LANES; g++) begin : g_mem_lane
      assign mem_copy_addr[g*ADDR_W +: ADDR_W] = ent_addr[lane_idx[g]];
      assign mem_copy_mask[g] = in_mem && lane_vld[g];
      assign mem_copy_pend[g] = mem_copy_mask[g] && ent_pend[lane_idx[g]];
      assign mem_copy_skip[g] = mem_copy_mask[g] && ent_skip[lane_idx[g]];
   end
endmodule

// File: rtl/srec_chk.sv
module srec_chk
   import srec_pkg::*;
#(
   parameter int ADDR_W      = 16,
   parameter int DEPTH       = 32,
   parameter int START_DELAY = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mispredict,
   input logic              lead_st_vld,
   input logic              trail_st_vld,
   input logic              busy,
   input logic              done,
   input logic              overflow,
   input logic              reg_copy_vld,
   input logic              mem_copy_vld,
   input srec_state_e       st,
   input logic [DEPTH-1:0]  ent_valid,
   input logic [ADDR_W-1:0] ent_addr [DEPTH]
);
   logic [7:0] busy_cyc;
   always_ff @(posedge clk) begin
      if (!rst_n || !busy) busy_cyc <= '0;
      else if (busy_cyc != 8'hFF) busy_cyc <= busy_cyc + 1'b1;
   end

   // R1: no two live entries share an address
   always @(posedge clk) begin
      if (rst_n) begin
         for (int i = 0; i < DEPTH; i++)
            for (int j = i + 1; j < DEPTH; j++)
               a_r1_unique: assert (!(ent_valid[i] && ent_valid[j] && ent_addr[i] == ent_addr[j]))
                  else $error("duplicate entry %0d/%0d", i, j);
      end
   end

   a_r5_quiet_start: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && busy_cyc < 8'(START_DELAY)) |-> (!reg_copy_vld && !mem_copy_vld));
   a_r5_first_beat: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(reg_copy_vld) |-> (busy_cyc == 8'(START_DELAY)));
   a_r7_after_regs: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_copy_vld && !$past(mem_copy_vld)) |-> $past(reg_copy_vld));
   a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_copy_vld && reg_copy_vld));
   a_r8_done_once: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done && !busy));
   a_r8_empty: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (ent_valid == '0 && !overflow));
   a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (overflow && !done) |=> overflow);
   a_r10_ignore: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_START && (lead_st_vld || trail_st_vld)) |=> $stable(ent_valid));
   a_r11_start_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(mispredict));
endmodule

bind store_recovery_ctrl srec_chk #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .START_DELAY(START_DELAY)) u_chk (
   .clk, .rst_n, .mispredict, .lead_st_vld, .trail_st_vld, .busy, .done, .overflow,
   .reg_copy_vld, .mem_copy_vld, .st, .ent_valid, .ent_addr
);

// File: tb/sim_store_recovery_ctrl.sv
module sim_store_recovery_ctrl;
   localparam int AW = 16, DEPTH = 32, CMAX = 15, LANES = 4, RB = 16, SD = 5, RW = 6;

   logic clk = 1'b0, rst_n = 1'b0;
   logic lv = 0, tv = 0, ts = 0, mp = 0;
   logic [AW-1:0] la = '0, ta = '0;
   logic reg_vld, mem_vld, busy, done, ovf;
   logic [LANES*RW-1:0] reg_idx;
   logic [LANES-1:0] reg_mask, mem_mask, mem_pend, mem_skip;
   logic [LANES*AW-1:0] mem_addr;

   int n_chk = 0, n_fail = 0;
   int m_cnt [int];
   bit m_skp [int];
   bit m_ovf = 0;

   always #2.5 clk = ~clk;

   store_recovery_ctrl u0 (
      .clk, .rst_n,
      .lead_st_vld(lv), .lead_st_addr(la),
      .trail_st_vld(tv), .trail_st_addr(ta), .trail_st_lead_skipped(ts),
      .mispredict(mp),
      .reg_copy_vld(reg_vld), .reg_copy_idx(reg_idx), .reg_copy_mask(reg_mask),
      .mem_copy_vld(mem_vld), .mem_copy_addr(mem_addr), .mem_copy_mask(mem_mask),
      .mem_copy_pend(mem_pend), .mem_copy_skip(mem_skip),
      .busy, .done, .overflow(ovf)
   );

   task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic void model_lead(input int a);
      if (m_cnt.exists(a)) begin
         if (m_cnt[a] == CMAX) m_ovf = 1;
         else m_cnt[a]++;
      end else if (m_cnt.num() == DEPTH) m_ovf = 1;
      else begin
         m_cnt[a] = 1;
         m_skp[a] = 0;
      end
   endfunction

   function automatic void model_trail(input int a, input bit skip);
      if (m_cnt.exists(a)) begin
         if (skip) m_skp[a] = 1;
         else if (m_cnt[a] > 0) m_cnt[a]--;
         if (m_cnt[a] == 0 && !m_skp[a]) begin
            m_cnt.delete(a);
            m_skp.delete(a);
         end
      end else if (skip) begin
         if (m_cnt.num() == DEPTH) m_ovf = 1;
         else begin
            m_cnt[a] = 0;
            m_skp[a] = 1;
         end
      end
   endfunction

   // one cycle of events; lead applied before trail (R12)
   task automatic ev(input bit l, input int lad, input bit t, input int tad, input bit sk);
      lv = l; la = AW'(lad); tv = t; ta = AW'(tad); ts = sk;
      if (l) model_lead(lad);
      if (t) model_trail(tad, sk);
      @(negedge clk);
      lv = 0; tv = 0; ts = 0;
   endtask

   // runs a repair; optionally injects stores and a second mispredict while busy
   task automatic recover(input string tag, input bit inject);
      int n, exp_mem, first_reg, regs, mems, done_at, mism, emitted, next_reg;
      int seen [int];
      n = m_cnt.num();
      exp_mem = (n + LANES - 1) / LANES;
      first_reg = -1; regs = 0; mems = 0; done_at = -1; mism = 0; emitted = 0; next_reg = 0;
      check(ovf == m_ovf, "R9", {tag, " overflow before repair"}, ovf, m_ovf);
      mp = 1;
      @(negedge clk);
      mp = 0;
      for (int c = 1; c < 200; c++) begin
         if (reg_vld) begin
            if (first_reg < 0) first_reg = c;
            regs++;
            for (int g = 0; g < LANES; g++) begin
               if (int'(reg_idx[g*RW +: RW]) != next_reg || !reg_mask[g]) mism++;
               next_reg++;
            end
         end
         if (mem_vld) begin
            mems++;
            for (int g = 0; g < LANES; g++) begin
               if (mem_mask[g]) begin
                  int a;
                  a = int'(mem_addr[g*AW +: AW]);
                  emitted++;
                  if (!m_cnt.exists(a) || seen.exists(a)) mism++;
                  else if (mem_pend[g] != (m_cnt[a] > 0) || mem_skip[g] != m_skp[a]) mism++;
                  seen[a] = 1;
               end
            end
         end
         if (done) begin
            done_at = c;
            break;
         end
         if (inject && c == 2) begin
            lv = 1; la = 16'hBEEF; tv = 1; ta = 16'hCAFE; ts = 1;
         end else if (inject && c == 8) begin
            lv = 0; tv = 0; ts = 0; mp = 1;
         end else begin
            lv = 0; tv = 0; ts = 0; mp = 0;
         end
         @(negedge clk);
      end
      lv = 0; tv = 0; ts = 0; mp = 0;
      check(first_reg == SD + 1, "R5", {tag, " first register beat cycle"}, first_reg, SD + 1);
      check(regs == RB, "R6", {tag, " register beats"}, regs, RB);
      check(mems == exp_mem, "R7", {tag, " memory beats"}, mems, exp_mem);
      check(emitted == n && mism == 0, "R1", {tag, " addresses once with flags (R2 R3 R4)"}, emitted + 1000*mism, n);
      check(done_at == SD + RB + exp_mem + 1, "R8", {tag, " done cycle"}, done_at, SD + RB + exp_mem + 1);
      @(negedge clk);
      check(!busy && !done && !ovf, "R8", {tag, " idle and clear after done"}, {busy, done, ovf}, 0);
      m_cnt.delete();
      m_skp.delete();
      m_ovf = 0;
   endtask

   initial begin
      #(200000 * 5);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      check(!busy && !done && !ovf && !reg_vld && !mem_vld, "R8", "reset state", {busy, done, ovf, reg_vld, mem_vld}, 0);

      // R2 + R1: repeated lead stores to one address, one entry
      ev(1, 10, 0, 0, 0); ev(1, 10, 0, 0, 0); ev(1, 20, 0, 0, 0);
      recover("R2 lead-only", 0);
      // R3: skipped trailing store
      ev(0, 0, 1, 30, 1); ev(1, 31, 0, 0, 0);
      recover("R3 skip", 0);
      // R4: count pairing, unmatched trailing store ignored
      ev(1, 40, 0, 0, 0); ev(1, 40, 0, 0, 0); ev(1, 40, 0, 0, 0);
      ev(0, 0, 1, 40, 0); ev(0, 0, 1, 40, 0); ev(0, 0, 1, 77, 0);
      recover("R4 partial pairing", 0);
      ev(1, 41, 0, 0, 0); ev(1, 41, 0, 0, 0);
      ev(0, 0, 1, 41, 0); ev(0, 0, 1, 41, 0);
      recover("R4 fully paired", 0);
      // R12: same-cycle pair to untracked address
      ev(1, 50, 1, 50, 0);
      recover("R12 same cycle", 0);
      // R9: full set and saturated count
      for (int i = 0; i < 33; i++) ev(1, 1000 + i, 0, 0, 0);
      check(ovf == 1, "R9", "overflow after 33 unique", ovf, 1);
      recover("R9 full set", 0);
      for (int i = 0; i < 16; i++) ev(1, 60, 0, 0, 0);
      check(ovf == 1, "R9", "overflow on saturated count", ovf, 1);
      recover("R9 saturation", 0);
      // R10 + R11: stores and mispredict during repair
      ev(1, 70, 0, 0, 0);
      recover("R11 injected", 1);
      recover("R10 nothing entered", 0);
      // random rounds
      for (int r = 0; r < 12; r++) begin
         for (int k = 0; k < 150; k++) begin
            int sel;
            sel = int'($urandom_range(0, 9));
            ev(sel < 5, int'($urandom_range(0, 19)), sel > 2, int'($urandom_range(0, 19)), $urandom_range(0, 6) == 0);
         end
         recover("R7 random", 0);
      end
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule